// File: doc/BRIEF.md
# Disc Seek Command Validator

This block checks a read or seek command addressed to a disc drive. The command gives a target position as six BCD digits: two for minutes, two for seconds and two for frames. The block turns the time code into a linear sector address. It then tests that address against the drive's current state, the table-of-contents valid flag and the end-of-disc address. A command that passes starts a seek to a physical sector placed a fixed pre-roll before the target. The drive then goes to play for a read command or to pause for a seek command. A command that fails raises a one-cycle error and leaves the seek target, the seek flag and the drive state as they were.

Each command is taken on a single-cycle strobe. The whole result appears in the next cycle, marked by a response pulse. The same evaluation also tidies the pending status-report format. When the drive state admits the command, a report format that selects table-of-contents data is switched back to absolute time.

Top module: `seek_cmd_validator`

## Requirements
- R1: The digit bus holds, from bits 23 down to 0, minutes tens, minutes units, seconds tens, seconds units, frames tens and frames units. The linear address is ((10·mt+mu)·60 + 10·st+su)·75 + 10·ft+fu. An accepted command sets the seek target to that address plus LEADIN_SECTORS minus 4.
- R2: A command is rejected when the drive state code is 5 (door open), 8 (tray moving), 0xC (lead-out) or 0xD (lead-in).
- R3: A command is rejected when the TOC-valid input is low.
- R4: A command is rejected when its linear address is greater than or equal to the end-of-disc address. An address one below that limit is accepted.
- R5: An accepted command sets the seek-active flag and reports no error. The next-state output becomes 1 (play) when the read bit is 1, and 4 (pause) when it is 0.
- R6: On a rejected command the error output is 1 and the next-state output equals the drive state input. The seek target and the seek-active flag keep their previous values.
- R7: If the drive state is not one of the codes in R2, a report format of 4 (track count) or 5 (track start) becomes 0 (absolute). This applies even when the command is rejected for R3 or R4. Every other format, including 3 (table span), passes through unchanged. When a command is rejected for R2, the format is never changed.
- R8: Every result appears in the cycle after the strobe, together with a one-cycle response pulse. No response appears without a strobe, and the error output is only high during a response.
- R9: After reset, the outputs are: response low, error low, target 0, seek-active low, next state 0 (stop), report format 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_read_i | input | 1 | 1 = read command, 0 = seek command |
| msf_digits_i | input | 24 | Six BCD digits of the target time code |
| drive_state_i | input | 4 | Current drive state code |
| toc_valid_i | input | 1 | Table of contents has been read |
| disc_end_lba_i | input | ADDR_W | First linear address beyond the disc |
| report_fmt_i | input | 4 | Pending status-report format |
| resp_valid_o | output | 1 | Result pulse, one cycle after the strobe |
| cmd_err_o | output | 1 | Command rejected |
| seek_target_o | output | ADDR_W+1 | Physical sector to seek to |
| seek_active_o | output | 1 | A seek has been started |
| next_state_o | output | 4 | Drive state after the command |
| report_fmt_o | output | 4 | Report format after the command |

## Verification
The bench uses the defaults: LEADIN_SECTORS = 150 and ADDR_W = 19. This puts the largest time code, 99:59:74 (address 449999), inside the address width, so the top of the conversion range can be tested with a target of 450145. A lead-in larger than the pre-roll also makes the offset visible in every accepted target, including the one for 00:00:00. The end-of-disc limit is set to 4500 so that both sides of the 01:00:00 boundary can be tested.

// File: rtl/seekval_pkg.sv
package seekval_pkg;

    localparam int DIGITS        = 6;
    localparam int FIELDS        = 3;
    localparam int FIELD_W       = 7;
    localparam int SECS_PER_MIN  = 60;
    localparam int FRAMES_PER_SEC = 75;
    localparam int PREROLL       = 4;

    typedef enum logic [3:0] {
        DRV_STOP        = 4'h0,
        DRV_PLAY        = 4'h1,
        DRV_SEEK        = 4'h2,
        DRV_SCAN        = 4'h3,
        DRV_PAUSE       = 4'h4,
        DRV_DOOR_OPEN   = 4'h5,
        DRV_TRAY_MOVING = 4'h8,
        DRV_TOC_READ    = 4'h9,
        DRV_NO_DISC     = 4'hB,
        DRV_LEADOUT     = 4'hC,
        DRV_LEADIN      = 4'hD
    } drive_state_e;

    typedef enum logic [3:0] {
        RPT_ABS       = 4'h0,
        RPT_REL       = 4'h1,
        RPT_TRACK     = 4'h2,
        RPT_TOC_SPAN  = 4'h3,
        RPT_TOC_COUNT = 4'h4,
        RPT_TOC_START = 4'h5,
        RPT_NOT_READY = 4'hF
    } report_fmt_e;

    typedef logic [FIELD_W-1:0] field_t;

    // binary value of a two-digit BCD field
    function automatic field_t bcd_pair(input logic [3:0] tens, input logic [3:0] units);
        return FIELD_W'(tens) * FIELD_W'(10) + FIELD_W'(units);
    endfunction

    // states in which the drive cannot position the head
    function automatic logic state_blocks_cmd(input drive_state_e st);
        return (st == DRV_DOOR_OPEN) || (st == DRV_TRAY_MOVING) ||
               (st == DRV_LEADOUT)   || (st == DRV_LEADIN);
    endfunction

    // report formats that read back table-of-contents data
    function automatic logic fmt_is_toc_lookup(input report_fmt_e f);
        return (f == RPT_TOC_COUNT) || (f == RPT_TOC_START);
    endfunction

endpackage

// File: rtl/msf_to_lba.sv
module msf_to_lba
    import seekval_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [DIGITS-1:0][3:0] digits_i,
    output logic [ADDR_W-1:0]      lba_o
);
    // field 0 = frames, 1 = seconds, 2 = minutes
    field_t fld [FIELDS];

    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        assign fld[g] = bcd_pair(digits_i[2*g+1], digits_i[2*g]);
    end

    logic [ADDR_W-1:0] total_secs;

    always_comb begin
        total_secs = ADDR_W'(fld[2]) * ADDR_W'(SECS_PER_MIN) + ADDR_W'(fld[1]);
        lba_o      = total_secs * ADDR_W'(FRAMES_PER_SEC) + ADDR_W'(fld[0]);
    end
endmodule

// File: rtl/seek_admission.sv
module seek_admission
    import seekval_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  drive_state_e      drive_state_i,
    input  logic              toc_valid_i,
    input  logic [ADDR_W-1:0] lba_i,
    input  logic [ADDR_W-1:0] end_lba_i,
    input  report_fmt_e       fmt_i,
    output logic              reject_o,
    output report_fmt_e       fmt_o
);
    logic state_bad, past_end;

    always_comb begin
        state_bad = state_blocks_cmd(drive_state_i);
        past_end  = (lba_i >= end_lba_i);
        reject_o  = state_bad || !toc_valid_i || past_end;
        // the format is only tidied once the state check has passed
        fmt_o     = (!state_bad && fmt_is_toc_lookup(fmt_i)) ? RPT_ABS : fmt_i;
    end
endmodule

// File: rtl/seek_result_regs.sv
module seek_result_regs
    import seekval_pkg::*;
#(
    parameter int ADDR_W         = 19,
    parameter int TGT_W          = 20,
    parameter int LEADIN_SECTORS = 150   // must be at least PREROLL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid_i,
    input  logic              cmd_read_i,
    input  logic              reject_i,
    input  logic [ADDR_W-1:0] lba_i,
    input  drive_state_e      drive_state_i,
    input  report_fmt_e       fmt_i,
    output logic              resp_valid_o,
    output logic              cmd_err_o,
    output logic [TGT_W-1:0]  seek_target_o,
    output logic              seek_active_o,
    output drive_state_e      next_state_o,
    output report_fmt_e       report_fmt_o
);
    localparam int OFFSET = LEADIN_SECTORS - PREROLL;

    logic [TGT_W-1:0] target_calc;
    assign target_calc = TGT_W'(lba_i) + TGT_W'(OFFSET);

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid_o  <= 1'b0;
            cmd_err_o     <= 1'b0;
            seek_target_o <= '0;
            seek_active_o <= 1'b0;
            next_state_o  <= DRV_STOP;
            report_fmt_o  <= RPT_ABS;
        end else begin
            resp_valid_o <= cmd_valid_i;
            cmd_err_o    <= cmd_valid_i && reject_i;
            if (cmd_valid_i) begin
                report_fmt_o <= fmt_i;
                if (reject_i) begin
                    next_state_o <= drive_state_i;
                end else begin
                    seek_target_o <= target_calc;
                    seek_active_o <= 1'b1;
                    next_state_o  <= cmd_read_i ? DRV_PLAY : DRV_PAUSE;
                end
            end
        end
    end
endmodule

// File: rtl/seek_cmd_validator.sv
module seek_cmd_validator
    import seekval_pkg::*;
#(
    parameter int ADDR_W         = 19,
    parameter int LEADIN_SECTORS = 150,
    localparam int TGT_W         = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid_i,
    input  logic              cmd_read_i,
    input  logic [23:0]       msf_digits_i,
    input  logic [3:0]        drive_state_i,
    input  logic              toc_valid_i,
    input  logic [ADDR_W-1:0] disc_end_lba_i,
    input  logic [3:0]        report_fmt_i,
    output logic              resp_valid_o,
    output logic              cmd_err_o,
    output logic [TGT_W-1:0]  seek_target_o,
    output logic              seek_active_o,
    output logic [3:0]        next_state_o,
    output logic [3:0]        report_fmt_o
);
    logic [DIGITS-1:0][3:0] digits;
    logic [ADDR_W-1:0]      lba_w;
    logic                   reject_w;
    report_fmt_e            fmt_w;
    drive_state_e           state_in;
    drive_state_e           state_q;
    report_fmt_e            fmt_q;

    assign digits   = msf_digits_i;
    assign state_in = drive_state_e'(drive_state_i);

    msf_to_lba #(.ADDR_W(ADDR_W)) u_conv (
        .digits_i (digits),
        .lba_o    (lba_w)
    );

    seek_admission #(.ADDR_W(ADDR_W)) u_admit (
        .drive_state_i (state_in),
        .toc_valid_i   (toc_valid_i),
        .lba_i         (lba_w),
        .end_lba_i     (disc_end_lba_i),
        .fmt_i         (report_fmt_e'(report_fmt_i)),
        .reject_o      (reject_w),
        .fmt_o         (fmt_w)
    );

    seek_result_regs #(
        .ADDR_W(ADDR_W), .TGT_W(TGT_W), .LEADIN_SECTORS(LEADIN_SECTORS)
    ) u_regs (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid_i   (cmd_valid_i),
        .cmd_read_i    (cmd_read_i),
        .reject_i      (reject_w),
        .lba_i         (lba_w),
        .drive_state_i (state_in),
        .fmt_i         (fmt_w),
        .resp_valid_o  (resp_valid_o),
        .cmd_err_o     (cmd_err_o),
        .seek_target_o (seek_target_o),
        .seek_active_o (seek_active_o),
        .next_state_o  (state_q),
        .report_fmt_o  (fmt_q)
    );

    assign next_state_o = state_q;
    assign report_fmt_o = fmt_q;
endmodule

// File: rtl/seek_cmd_validator_chk.sv
module seek_cmd_validator_chk #(
    parameter int ADDR_W = 19,
    parameter int TGT_W  = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid_i,
    input logic [3:0]        drive_state_i,
    input logic              toc_valid_i,
    input logic [ADDR_W-1:0] disc_end_lba_i,
    input logic [ADDR_W-1:0] lba_w,
    input logic              resp_valid_o,
    input logic              cmd_err_o,
    input logic [TGT_W-1:0]  seek_target_o,
    input logic              seek_active_o,
    input logic [3:0]        next_state_o
);
    logic blocked;
    assign blocked = (drive_state_i == 4'h5) || (drive_state_i == 4'h8) ||
                     (drive_state_i == 4'hC) || (drive_state_i == 4'hD);

    assert_blocked_state_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_i && blocked |=> cmd_err_o);

    assert_toc_missing_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_i && !toc_valid_i |=> cmd_err_o);

    assert_beyond_end_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_i && (lba_w >= disc_end_lba_i) |=> cmd_err_o);

    assert_accept_moves_R5: assert property (@(posedge clk) disable iff (rst)
        resp_valid_o && !cmd_err_o |-> seek_active_o &&
        ((next_state_o == 4'h1) || (next_state_o == 4'h4)));

    assert_reject_holds_R6: assert property (@(posedge clk) disable iff (rst)
        resp_valid_o && cmd_err_o |-> $stable(seek_target_o) && $stable(seek_active_o));

    assert_reject_echo_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_i && blocked |=> next_state_o == $past(drive_state_i));

    assert_resp_after_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_i |=> resp_valid_o);

    assert_no_stray_resp_R8: assert property (@(posedge clk) disable iff (rst)
        resp_valid_o |-> $past(cmd_valid_i));

    assert_err_in_resp_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_err_o |-> resp_valid_o);
endmodule

bind seek_cmd_validator seek_cmd_validator_chk #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cmd_valid_i    (cmd_valid_i),
    .drive_state_i  (drive_state_i),
    .toc_valid_i    (toc_valid_i),
    .disc_end_lba_i (disc_end_lba_i),
    .lba_w          (lba_w),
    .resp_valid_o   (resp_valid_o),
    .cmd_err_o      (cmd_err_o),
    .seek_target_o  (seek_target_o),
    .seek_active_o  (seek_active_o),
    .next_state_o   (next_state_o)
);

// File: tb/tb_seek_cmd_validator.sv
module tb_seek_cmd_validator;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 19;
    localparam int LEADIN     = 150;
    localparam int TGT_W      = ADDR_W + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic              cmd_read = 1'b0;
    logic [23:0]       digits = '0;
    logic [3:0]        dstate = '0;
    logic              toc_ok = 1'b0;
    logic [ADDR_W-1:0] end_lba = '0;
    logic [3:0]        fmt_in = '0;
    logic              resp_valid, cmd_err, seek_active;
    logic [TGT_W-1:0]  seek_target;
    logic [3:0]        next_state, fmt_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    seek_cmd_validator #(.ADDR_W(ADDR_W), .LEADIN_SECTORS(LEADIN)) dut (
        .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_read_i(cmd_read),
        .msf_digits_i(digits), .drive_state_i(dstate), .toc_valid_i(toc_ok),
        .disc_end_lba_i(end_lba), .report_fmt_i(fmt_in),
        .resp_valid_o(resp_valid), .cmd_err_o(cmd_err), .seek_target_o(seek_target),
        .seek_active_o(seek_active), .next_state_o(next_state), .report_fmt_o(fmt_out)
    );

    typedef struct {
        logic       err;
        logic [3:0] st;
        int         tgt;
        logic       act;
        logic [3:0] fmt;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;

    // reference model state
    int       m_tgt = 0;
    logic     m_act = 1'b0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic issue(input bit rd, input int mn, input int sc, input int fr,
                         input logic [3:0] st, input bit toc, input int endl,
                         input logic [3:0] fmt, input string tag);
        exp_t e;
        int   lba;
        bit   bad, rej;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_read  = rd;
        digits    = {4'(mn/10), 4'(mn%10), 4'(sc/10), 4'(sc%10), 4'(fr/10), 4'(fr%10)};
        dstate    = st;
        toc_ok    = toc;
        end_lba   = ADDR_W'(endl);
        fmt_in    = fmt;
        lba = (mn * 60 + sc) * 75 + fr;
        bad = (st == 4'h5) || (st == 4'h8) || (st == 4'hC) || (st == 4'hD);
        rej = bad || !toc || (lba >= endl);
        e.err = rej;
        e.fmt = (!bad && (fmt == 4'h4 || fmt == 4'h5)) ? 4'h0 : fmt;
        if (rej) begin
            e.st = st;
        end else begin
            m_tgt = lba + LEADIN - 4;
            m_act = 1'b1;
            e.st  = rd ? 4'h1 : 4'h4;
        end
        e.tgt = m_tgt;
        e.act = m_act;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
        end
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (cmd_err && !resp_valid)
                    check("R8", "error outside response", 1, 0);
                if (resp_valid) begin
                    if (exp_q.size() == 0) begin
                        check("R8", "response without strobe", 1, 0);
                    end else begin
                        exp_t  e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(t, "error", int'(cmd_err), int'(e.err));
                        check(t, "next state", int'(next_state), int'(e.st));
                        check(t, "seek target", int'(seek_target), e.tgt);
                        check(t, "seek active", int'(seek_active), int'(e.act));
                        check(t, "report format", int'(fmt_out), int'(e.fmt));
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset values
        check("R9", "resp", int'(resp_valid), 0);
        check("R9", "err", int'(cmd_err), 0);
        check("R9", "target", int'(seek_target), 0);
        check("R9", "active", int'(seek_active), 0);
        check("R9", "state", int'(next_state), 0);
        check("R9", "format", int'(fmt_out), 0);

        // R3/R6: first command rejected, nothing started; R7 forcing on toc reject
        issue(1, 0, 2, 0, 4'h0, 0, 300000, 4'h4, "R3_R6_R7");
        idle(1);
        // R1/R5: read 00:02:00 -> address 150, target 296, play
        issue(1, 0, 2, 0, 4'h4, 1, 300000, 4'h1, "R1_R5");
        // R1/R5 back-to-back: seek 12:34:56 -> 56606, target 56752, pause
        issue(0, 12, 34, 56, 4'h1, 1, 300000, 4'h3, "R1_R5_R7");
        // R2: each blocking state, target held, format untouched
        issue(1, 1, 0, 0, 4'h5, 1, 300000, 4'h5, "R2_R6_R7");
        issue(1, 1, 0, 0, 4'h8, 1, 300000, 4'h4, "R2_R6");
        issue(0, 1, 0, 0, 4'hC, 1, 300000, 4'h2, "R2");
        issue(0, 1, 0, 0, 4'hD, 1, 300000, 4'h0, "R2");
        idle(2);
        // R4: boundary at 01:00:00 = 4500
        issue(1, 1, 0, 0, 4'h4, 1, 4500, 4'h5, "R4_R7");
        issue(1, 0, 59, 74, 4'h4, 1, 4500, 4'h5, "R4_R7");
        issue(0, 5, 0, 0, 4'h1, 1, 4500, 4'h1, "R4_R6");
        // R1 corners: 00:00:00 and 99:59:74
        issue(0, 0, 0, 0, 4'h0, 1, 300000, 4'h2, "R1");
        issue(1, 99, 59, 74, 4'h4, 1, 450000, 4'hF, "R1_R5");
        issue(0, 99, 59, 74, 4'h4, 1, 449999, 4'h3, "R4");
        idle(4);
        check("R8", "responses outstanding", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule